// File: doc/BRIEF.md
# Add/Subtract Unit with Carry and Overflow Flags

This unit performs every 32-bit integer addition and subtract-from variant of a load-store processor's integer pipe, together with negation. One operand can be inverted, the second operand can be swapped for all-zeros or all-ones, and the carry into the low bit can be forced to 0 or 1, or taken from the current carry flag. Eleven distinct operations therefore share a single carry chain.

Beside the sum, the unit returns the new carry, overflow and sticky summary-overflow flags. On request it also returns a 4-bit condition nibble that compares the result, as a signed value, with zero. The datapath is purely combinational. A valid strobe loads all outputs into registers, and the results appear one clock later. An extended-opcode value outside the eleven supported ones produces an illegal indication and returns every flag unchanged.

Top module: `addu_top`

## Requirements
- R1: The add forms are selected by extended opcode 266 (A+B), 10 (A+B), 138 (A+B+CA), 202 (A+CA) and 234 (A+0xFFFFFFFF+CA). The result is the low 32 bits of the sum.
- R2: The subtract-from forms are selected by opcode 40 (~A+B+1), 8 (~A+B+1), 136 (~A+B+CA), 200 (~A+CA) and 232 (~A+0xFFFFFFFF+CA). The result is the low 32 bits.
- R3: Opcodes 10, 138, 202, 234, 8, 136, 200 and 232 write the carry flag. Its new value is bit 32 of the 33-bit sum of the zero-extended terms.
- R4: Opcodes 266, 40 and 104 return the incoming carry unchanged.
- R5: Opcode 104 returns the two's complement of A. Negating 0x80000000 returns 0x80000000 and counts as a signed overflow.
- R6: When ovEnable is 1, ovOut is the signed overflow of the operation. When ovEnable is 0, ovOut equals ovIn.
- R7: sumOvOut = sumOvIn OR (ovEnable AND overflow). No operation ever clears it.
- R8: When recordEn is 1 on a legal opcode, condValid is 1 and condField is {negative, positive, zero, sumOvOut} in bits 3..0. Otherwise condValid and condField are 0.
- R9: Any other opcode sets illegal and returns result 0. carryOut, ovOut and sumOvOut equal their inputs, and condValid is 0.
- R10: Outputs load on the clock edge where inValid is 1. outValid pulses for one cycle and the outputs hold while inValid is 0. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Load strobe for the current inputs |
| opA | input | 32 | First operand (inverted by subtract forms) |
| opB | input | 32 | Second operand |
| xOpcode | input | 10 | Extended opcode |
| ovEnable | input | 1 | Overflow-enable bit |
| recordEn | input | 1 | Record bit: request the condition nibble |
| carryIn | input | 1 | Current carry flag |
| ovIn | input | 1 | Current overflow flag |
| sumOvIn | input | 1 | Current summary-overflow flag |
| outValid | output | 1 | One-cycle pulse when new results load |
| result | output | 32 | Sum |
| carryOut | output | 1 | Updated carry flag |
| ovOut | output | 1 | Updated overflow flag |
| sumOvOut | output | 1 | Updated summary-overflow flag |
| condField | output | 4 | Condition nibble |
| condValid | output | 1 | Condition nibble is meaningful |
| illegal | output | 1 | Opcode not supported |

## Verification
The bench targets the carry-in selection of the extended, minus-one and zero forms with both values of the incoming carry. A wrong selection shows up as a result that is off by one and a wrong carry when A is 0 or all-ones. It drives the 0x7FFFFFFF/0x80000000 boundaries, where a design that derives overflow from the wrong carry pair flags unsigned wrap instead of signed overflow. It also negates the most negative number, where a bad design returns 0 or misses the overflow. The plain add, subf and negate forms are checked for leaving the carry untouched, and the sticky bit is checked for never being cleared by a non-overflowing operation. A sweep over all 1024 opcode values confirms that only the eleven supported encodings escape the illegal path with its frozen flags.

// File: rtl/addu_pkg.sv
package addu_pkg;

  localparam int OPC_W = 10;

  localparam logic [OPC_W-1:0] OPC_ADD    = 10'd266;
  localparam logic [OPC_W-1:0] OPC_ADDC   = 10'd10;
  localparam logic [OPC_W-1:0] OPC_ADDE   = 10'd138;
  localparam logic [OPC_W-1:0] OPC_ADDZE  = 10'd202;
  localparam logic [OPC_W-1:0] OPC_ADDME  = 10'd234;
  localparam logic [OPC_W-1:0] OPC_SUBF   = 10'd40;
  localparam logic [OPC_W-1:0] OPC_SUBFC  = 10'd8;
  localparam logic [OPC_W-1:0] OPC_SUBFE  = 10'd136;
  localparam logic [OPC_W-1:0] OPC_SUBFZE = 10'd200;
  localparam logic [OPC_W-1:0] OPC_SUBFME = 10'd232;
  localparam logic [OPC_W-1:0] OPC_NEG    = 10'd104;

  // Second adder term
  typedef enum logic [1:0] {
    B_OPER = 2'd0,
    B_ZERO = 2'd1,
    B_ONES = 2'd2
  } bSel_e;

  // Carry into bit 0
  typedef enum logic [1:0] {
    CI_ZERO  = 2'd0,
    CI_ONE   = 2'd1,
    CI_CARRY = 2'd2
  } ciSel_e;

  typedef struct packed {
    logic   legal;
    logic   invA;
    bSel_e  bSel;
    ciSel_e ciSel;
    logic   writeCa;
  } addStrobe_t;

endpackage

// File: rtl/addu_ctrl.sv
module addu_ctrl
  import addu_pkg::*;
(
  input  logic [OPC_W-1:0] xOpcode,
  output addStrobe_t       strb
);

  always_comb begin
    strb = '{legal: 1'b1, invA: 1'b0, bSel: B_OPER, ciSel: CI_ZERO, writeCa: 1'b0};
    case (xOpcode)
      OPC_ADD:    strb = '{legal: 1'b1, invA: 1'b0, bSel: B_OPER, ciSel: CI_ZERO,  writeCa: 1'b0};
      OPC_ADDC:   strb = '{legal: 1'b1, invA: 1'b0, bSel: B_OPER, ciSel: CI_ZERO,  writeCa: 1'b1};
      OPC_ADDE:   strb = '{legal: 1'b1, invA: 1'b0, bSel: B_OPER, ciSel: CI_CARRY, writeCa: 1'b1};
      OPC_ADDZE:  strb = '{legal: 1'b1, invA: 1'b0, bSel: B_ZERO, ciSel: CI_CARRY, writeCa: 1'b1};
      OPC_ADDME:  strb = '{legal: 1'b1, invA: 1'b0, bSel: B_ONES, ciSel: CI_CARRY, writeCa: 1'b1};
      OPC_SUBF:   strb = '{legal: 1'b1, invA: 1'b1, bSel: B_OPER, ciSel: CI_ONE,   writeCa: 1'b0};
      OPC_SUBFC:  strb = '{legal: 1'b1, invA: 1'b1, bSel: B_OPER, ciSel: CI_ONE,   writeCa: 1'b1};
      OPC_SUBFE:  strb = '{legal: 1'b1, invA: 1'b1, bSel: B_OPER, ciSel: CI_CARRY, writeCa: 1'b1};
      OPC_SUBFZE: strb = '{legal: 1'b1, invA: 1'b1, bSel: B_ZERO, ciSel: CI_CARRY, writeCa: 1'b1};
      OPC_SUBFME: strb = '{legal: 1'b1, invA: 1'b1, bSel: B_ONES, ciSel: CI_CARRY, writeCa: 1'b1};
      OPC_NEG:    strb = '{legal: 1'b1, invA: 1'b1, bSel: B_ZERO, ciSel: CI_ONE,   writeCa: 1'b0};
      default:    strb = '{legal: 1'b0, invA: 1'b0, bSel: B_ZERO, ciSel: CI_ZERO,  writeCa: 1'b0};
    endcase
  end

endmodule

// File: rtl/addu_dp.sv
module addu_dp
  import addu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addStrobe_t       strb,
  input  logic             carryIn,
  input  logic             ovIn,
  input  logic             sumOvIn,
  input  logic             ovEnable,
  input  logic             recordEn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             ovOut,
  output logic             sumOvOut,
  output logic [3:0]       condField,
  output logic             condValid,
  output logic             illegal
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] xTerm;
  logic [WIDTH-1:0] yTerm;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   chain;
  logic             signedOv;
  logic             stickyNext;
  logic             isNeg;
  logic             isZero;

  always_comb begin
    xTerm = strb.invA ? ~opA : opA;
    case (strb.bSel)
      B_OPER:  yTerm = opB;
      B_ONES:  yTerm = '1;
      default: yTerm = '0;
    endcase
    case (strb.ciSel)
      CI_ONE:   chain[0] = 1'b1;
      CI_CARRY: chain[0] = carryIn;
      default:  chain[0] = 1'b0;
    endcase
  end

  // One full-adder cell per bit; the carry into the top bit is kept for overflow
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sumBits[i]  = xTerm[i] ^ yTerm[i] ^ chain[i];
    assign chain[i+1]  = (xTerm[i] & yTerm[i]) | (chain[i] & (xTerm[i] ^ yTerm[i]));
  end

  assign signedOv   = chain[WIDTH] ^ chain[MSB];
  assign stickyNext = sumOvIn | (ovEnable & signedOv);
  assign isNeg      = sumBits[MSB];
  assign isZero     = ~|sumBits;

  always_comb begin
    illegal = ~strb.legal;
    if (!strb.legal) begin
      result    = '0;
      carryOut  = carryIn;
      ovOut     = ovIn;
      sumOvOut  = sumOvIn;
      condField = 4'd0;
      condValid = 1'b0;
    end else begin
      result    = sumBits;
      carryOut  = strb.writeCa ? chain[WIDTH] : carryIn;
      ovOut     = ovEnable ? signedOv : ovIn;
      sumOvOut  = stickyNext;
      condValid = recordEn;
      condField = recordEn ? {isNeg, ~isNeg & ~isZero, isZero, stickyNext} : 4'd0;
    end
  end

endmodule

// File: rtl/addu_top.sv
module addu_top
  import addu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OPC_W-1:0] xOpcode,
  input  logic             ovEnable,
  input  logic             recordEn,
  input  logic             carryIn,
  input  logic             ovIn,
  input  logic             sumOvIn,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             ovOut,
  output logic             sumOvOut,
  output logic [3:0]       condField,
  output logic             condValid,
  output logic             illegal
);

  addStrobe_t       strb;
  logic [WIDTH-1:0] resNext;
  logic             caNext;
  logic             ovNext;
  logic             soNext;
  logic [3:0]       cfNext;
  logic             cvNext;
  logic             illNext;

  addu_ctrl ctrl_i (
    .xOpcode (xOpcode),
    .strb    (strb)
  );

  addu_dp #(.WIDTH(WIDTH)) dp_i (
    .opA       (opA),
    .opB       (opB),
    .strb      (strb),
    .carryIn   (carryIn),
    .ovIn      (ovIn),
    .sumOvIn   (sumOvIn),
    .ovEnable  (ovEnable),
    .recordEn  (recordEn),
    .result    (resNext),
    .carryOut  (caNext),
    .ovOut     (ovNext),
    .sumOvOut  (soNext),
    .condField (cfNext),
    .condValid (cvNext),
    .illegal   (illNext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      result    <= '0;
      carryOut  <= 1'b0;
      ovOut     <= 1'b0;
      sumOvOut  <= 1'b0;
      condField <= 4'd0;
      condValid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result    <= resNext;
        carryOut  <= caNext;
        ovOut     <= ovNext;
        sumOvOut  <= soNext;
        condField <= cfNext;
        condValid <= cvNext;
        illegal   <= illNext;
      end
    end
  end

  // R10: one-cycle latency pulse, outputs hold when idle
  p_valid_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(result) && $stable(carryOut)));

  // R7: sticky bit never drops
  p_sticky_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && sumOvIn) |=> sumOvOut);

  // R6: without enable, overflow passes through
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !ovEnable) |=> (ovOut == $past(ovIn) && sumOvOut == $past(sumOvIn)));

  // R4: plain add, subf and negate keep the carry
  p_carry_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (xOpcode == OPC_ADD || xOpcode == OPC_SUBF || xOpcode == OPC_NEG))
    |=> (carryOut == $past(carryIn)));

  // R9: illegal opcode freezes flags
  p_illegal_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && illegal) |-> (!condValid && result == '0));

  // R8: exactly one sign class in the condition nibble
  p_cond_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    condValid |-> ($countones(condField[3:1]) == 1));

endmodule

// File: tb/addu_top_tb_top.sv
`timescale 1ns/1ps
module addu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [9:0]  xOpcode = '0;
  logic        ovEnable = 1'b0, recordEn = 1'b0, carryIn = 1'b0, ovIn = 1'b0, sumOvIn = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic        carryOut, ovOut, sumOvOut, condValid, illegal;
  logic [3:0]  condField;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  addu_top dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
    .xOpcode(xOpcode), .ovEnable(ovEnable), .recordEn(recordEn),
    .carryIn(carryIn), .ovIn(ovIn), .sumOvIn(sumOvIn),
    .outValid(outValid), .result(result), .carryOut(carryOut), .ovOut(ovOut),
    .sumOvOut(sumOvOut), .condField(condField), .condValid(condValid), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h (opc %0d A %h B %h ca %b oe %b)",
               req, act, exp, xOpcode, opA, opB, carryIn, ovEnable);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finishRun();
    end
  end

  function automatic bit isLegal(input int opc);
    return opc == 266 || opc == 10 || opc == 138 || opc == 202 || opc == 234 ||
           opc == 40  || opc == 8  || opc == 136 || opc == 200 || opc == 232 || opc == 104;
  endfunction

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'hFFFF_FFFE;
      6: return 32'h1234_5678;
      default: return 32'hA5A5_F00F;
    endcase
  endfunction

  // Arithmetic reference built from the requirement formulas
  task automatic model(output logic [31:0] eRes, output logic eCa, output logic eOv,
                       output logic eSo, output logic [3:0] eCf);
    longint unsigned a, b, inv, c, full;
    logic [31:0] x, y;
    bit writes, sx, sy, sr, ovf;
    a = {32'd0, opA};
    b = {32'd0, opB};
    inv = {32'd0, ~opA};
    c = {63'd0, carryIn};
    writes = 1'b1;
    case (xOpcode)
      266: begin full = a + b;             x = opA;  y = opB; writes = 0; end
      10:  begin full = a + b;             x = opA;  y = opB; end
      138: begin full = a + b + c;         x = opA;  y = opB; end
      202: begin full = a + c;             x = opA;  y = 0;   end
      234: begin full = a + 64'hFFFF_FFFF + c; x = opA; y = '1; end
      40:  begin full = inv + b + 1;       x = ~opA; y = opB; writes = 0; end
      8:   begin full = inv + b + 1;       x = ~opA; y = opB; end
      136: begin full = inv + b + c;       x = ~opA; y = opB; end
      200: begin full = inv + c;           x = ~opA; y = 0;   end
      232: begin full = inv + 64'hFFFF_FFFF + c; x = ~opA; y = '1; end
      default: begin full = 64'd0 - a;     x = ~opA; y = 0; writes = 0; end
    endcase
    eRes = full[31:0];
    eCa = writes ? full[32] : carryIn;
    sx = x[31]; sy = y[31]; sr = eRes[31];
    ovf = (sx == sy) && (sr != sx);
    if (xOpcode == 10'd104) ovf = (opA == 32'h8000_0000);
    eOv = ovEnable ? ovf : ovIn;
    eSo = sumOvIn | (ovEnable & ovf);
    if (recordEn)
      eCf = {sr, (!sr && eRes != 0), (eRes == 0), eSo};
    else
      eCf = 4'd0;
  endtask

  task automatic apply();
    @(negedge clk);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    logic [31:0] eRes;
    logic eCa, eOv, eSo;
    logic [3:0] eCf;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(outValid == 0 && result == 0 && carryOut == 0 && sumOvOut == 0 && condField == 0 && illegal == 0,
          "R10 reset", {result[30:0], outValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 11; op++) begin
      int opcList[11] = '{266, 10, 138, 202, 234, 40, 8, 136, 200, 232, 104};
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int f = 0; f < 16; f++) begin
            @(negedge clk);
            xOpcode  = opcList[op][9:0];
            opA      = pattern(i);
            opB      = pattern(j);
            carryIn  = f[0];
            ovEnable = f[1];
            recordEn = f[2];
            sumOvIn  = f[3];
            ovIn     = f[0] ^ f[3];
            apply();
            model(eRes, eCa, eOv, eSo, eCf);
            if (op < 5)       check(result == eRes, "R1 add result", result, eRes);
            else if (op < 10) check(result == eRes, "R2 subtract result", result, eRes);
            else              check(result == eRes, "R5 negate result", result, eRes);
            if (op == 0 || op == 5 || op == 10)
              check(carryOut == eCa, "R4 carry kept", {31'd0, carryOut}, {31'd0, eCa});
            else
              check(carryOut == eCa, "R3 carry written", {31'd0, carryOut}, {31'd0, eCa});
            check(ovOut == eOv, "R6 overflow", {31'd0, ovOut}, {31'd0, eOv});
            check(sumOvOut == eSo, "R7 sticky", {31'd0, sumOvOut}, {31'd0, eSo});
            check(condField == eCf && condValid == recordEn && !illegal, "R8 condition",
                  {27'd0, condValid, condField}, {27'd0, recordEn, eCf});
            check(outValid == 1'b1, "R10 pulse", {31'd0, outValid}, 32'd1);
          end
        end
      end
      // R10: outputs hold across an idle cycle
      eRes = result;
      @(negedge clk);
      check(outValid == 0 && result == eRes, "R10 hold", result, eRes);
    end

    // R5: explicit most-negative negate
    xOpcode = 10'd104; opA = 32'h8000_0000; ovEnable = 1; ovIn = 0; sumOvIn = 0; carryIn = 0; recordEn = 0;
    apply();
    check(result == 32'h8000_0000 && ovOut && sumOvOut, "R5 negate min",
          result, 32'h8000_0000);

    // R9: full opcode sweep
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      xOpcode = k[9:0]; opA = 32'h0000_0005; opB = 32'h7FFF_FFFF;
      carryIn = 1; ovIn = 1; sumOvIn = 0; ovEnable = 1; recordEn = 1;
      apply();
      if (isLegal(k))
        check(!illegal, "R9 legal opcode", {31'd0, illegal}, 32'd0);
      else
        check(illegal && result == 0 && carryOut && ovOut && !sumOvOut && !condValid,
              "R9 illegal frozen", {27'd0, illegal, carryOut, ovOut, sumOvOut, condValid},
              {27'd0, 5'b11100});
    end

    finishRun();
  end

endmodule